// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block steps a small processor core through its instructions one T-state per clock. Every instruction starts with an opcode fetch. After decoding, the block issues the extra machine cycles the instruction needs. It requests each machine cycle from an external bus controller by driving a 3-bit cycle status, an address, a write byte and read/write strobes. It samples `bus_ready` in the second T-state of each memory cycle. While `bus_ready` is low it holds the cycle in wait states.

The core holds a 16-bit program counter, an instruction register, a 16-bit temporary address register, an accumulator, register B, and a register C fixed by a parameter. It runs four instructions, each with a one-byte opcode:

- 41H copies C into B.
- 06H loads B from an immediate byte.
- C6H adds an immediate byte to the accumulator.
- 32H stores the accumulator at a two-byte address.

Any other opcode runs as a 4-state no-operation. When an instruction ends, the block pulses `instr_done` for one clock and presents the T-state count of that instruction, wait states included.

Top module: `mc_sequencer`

## Requirements
- R1: While reset is low, and in the first clock after it is released, the block is in T1 of an opcode fetch: `mc_t1`=1, `mc_status`=3'b011, `mc_addr`=0000H. In the same state `pc_out`, `acc_out` and `b_out` read 0, and `instr_done`=0.
- R2: An opcode fetch lasts 4 T-states when there are no wait states. Opcode 41H copies C into B during T4 and ends the instruction after 4 T-states.
- R3: Opcode 06H reads one immediate byte in a 3-state memory read (status 3'b010), loads it into B, and takes 7 T-states in total.
- R4: Opcode C6H reads one immediate byte and replaces the accumulator with the sum of the two, modulo 256. It takes 7 T-states.
- R5: Opcode 32H runs four machine cycles with statuses 011, 010, 010, 001 in that order, for 13 T-states in total. The first read byte is the low address and the second is the high address. The write then puts the accumulator at {high,low}.
- R6: The program counter increments by exactly one for each instruction byte read. When `instr_done` pulses, it points at the next opcode.
- R7: Any opcode other than 41H, 06H, C6H and 32H takes 4 T-states and leaves the accumulator and B unchanged.
- R8: Each clock in T2 with `bus_ready` low adds one wait state. Wait states hold the address and status, and they are counted in `tcount`.
- R9: `rd_en` is high in T2 (with its wait states) and T3 of fetch and read cycles. `wr_en` is high in the same T-states of the write cycle. The two are never high together.
- R10: `instr_done` is a one-clock pulse after the last T-state of each instruction, carrying that instruction's T-state total in `tcount`. In the same clock the next opcode fetch is in T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ready | input | 1 | Memory ready, sampled in T2; low inserts a wait state |
| bus_rdata | input | 8 | Read byte, captured at the end of T3 |
| mc_status | output | 3 | Cycle type: 011 opcode fetch, 010 memory read, 001 memory write |
| mc_t1 | output | 1 | High during T1 of each machine cycle |
| mc_addr | output | 16 | Cycle address |
| mc_wdata | output | 8 | Write byte (accumulator) |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| instr_done | output | 1 | One-clock pulse at the end of an instruction |
| tcount | output | CW | T-states taken by the last instruction |
| pc_out | output | 16 | Program counter |
| acc_out | output | 8 | Accumulator |
| b_out | output | 8 | Register B |

## Verification
The hardest case to reach from the ports is a wait state in a machine cycle other than the opcode fetch, above all the write of a store. There the held address comes from the temporary register rather than the program counter.

The bench's bus model inserts two wait states into every cycle whose T1 address falls in 0010H..00FFH. A store placed there, whose target is also in that window, then meets waits in all four of its cycles. The expected total is 21 T-states.

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter logic [7:0] C_INIT = 8'h5A,
  parameter int         CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata,
  output logic [2:0]    mc_status,
  output logic          mc_t1,
  output logic [15:0]   mc_addr,
  output logic [7:0]    mc_wdata,
  output logic          rd_en,
  output logic          wr_en,
  output logic          instr_done,
  output logic [CW-1:0] tcount,
  output logic [15:0]   pc_out,
  output logic [7:0]    acc_out,
  output logic [7:0]    b_out
);
  localparam logic [7:0] OP_MOVBC = 8'h41;
  localparam logic [7:0] OP_MVIB  = 8'h06;
  localparam logic [7:0] OP_ADI   = 8'hC6;
  localparam logic [7:0] OP_STA   = 8'h32;

  typedef enum logic [1:0] {M_OF, M_LO, M_HI, M_WR} mc_e;

  mc_e           mc;
  logic [1:0]    ts;
  logic [15:0]   pc, tmp;
  logic [7:0]    ir, acc, b;
  logic [CW-1:0] cnt;
  logic          done_q;

  logic wait_st, has_imm, last;
  assign wait_st = (ts == 2'd1) && !bus_ready;
  assign has_imm = (ir == OP_MVIB) || (ir == OP_ADI) || (ir == OP_STA);
  assign last    = (mc == M_OF && ts == 2'd3 && !has_imm)
                || (mc == M_LO && ts == 2'd2 && ir != OP_STA)
                || (mc == M_WR && ts == 2'd2);

  assign mc_status  = (mc == M_OF) ? 3'b011 : (mc == M_WR) ? 3'b001 : 3'b010;
  assign mc_t1      = (ts == 2'd0);
  assign mc_addr    = (mc == M_WR) ? tmp : pc;
  assign mc_wdata   = acc;
  assign rd_en      = (mc != M_WR) && (ts == 2'd1 || ts == 2'd2);
  assign wr_en      = (mc == M_WR) && (ts == 2'd1 || ts == 2'd2);
  assign instr_done = done_q;
  assign pc_out     = pc;
  assign acc_out    = acc;
  assign b_out      = b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc <= M_OF; ts <= 2'd0; pc <= '0; tmp <= '0; ir <= '0;
      acc <= '0; b <= '0; cnt <= '0; tcount <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (last) begin
        cnt    <= '0;
        tcount <= cnt + 1'b1;
        done_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
      case (ts)
        2'd0: ts <= 2'd1;
        2'd1: if (bus_ready) ts <= 2'd2;
        2'd2: begin
          ts <= 2'd0;
          case (mc)
            M_OF: begin ir <= bus_rdata; pc <= pc + 16'd1; ts <= 2'd3; end
            M_LO: begin
              pc <= pc + 16'd1;
              if (ir == OP_STA) begin
                tmp[7:0] <= bus_rdata;
                mc <= M_HI;
              end else begin
                if (ir == OP_MVIB) b <= bus_rdata;
                else acc <= acc + bus_rdata;
                mc <= M_OF;
              end
            end
            M_HI: begin pc <= pc + 16'd1; tmp[15:8] <= bus_rdata; mc <= M_WR; end
            default: mc <= M_OF;
          endcase
        end
        default: begin
          ts <= 2'd0;
          if (ir == OP_MOVBC) b <= C_INIT;
          if (has_imm) mc <= M_LO;
        end
      endcase
    end
  end

  AST_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (mc_t1 && mc_status == 3'b011)); // R10
  AST_MIN_TSTATES: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (tcount >= CW'(4))); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R9
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wait_st |=> ($stable(mc_addr) && $stable(mc_status) && !mc_t1)); // R8
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == $past(pc) + 16'd1)); // R6
endmodule

// File: tb/sim_mc_sequencer.sv
module sim_mc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ready = 1'b1;
  logic [7:0]  bus_rdata;
  logic [2:0]  mc_status;
  logic        mc_t1, rd_en, wr_en, instr_done;
  logic [15:0] mc_addr, pc_out;
  logic [7:0]  mc_wdata, acc_out, b_out, tcount;

  always #2 clk = ~clk;

  mc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .mc_status(mc_status), .mc_t1(mc_t1), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
    .rd_en(rd_en), .wr_en(wr_en), .instr_done(instr_done), .tcount(tcount),
    .pc_out(pc_out), .acc_out(acc_out), .b_out(b_out)
  );

  logic [7:0] mem [0:255];
  assign bus_rdata = mem[mc_addr[7:0]];

  int checks = 0, fails = 0, dones = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] tc, acc, b, pc, seq, nseq, wr, wa, wd;
  } exp_t;
  exp_t  q[$];
  string tags[$];

  task automatic push(input string tag, input int tc, input int acc, input int b, input int pc,
                      input int seq, input int nseq, input int wr, input int wa, input int wd);
    exp_t e;
    e.tc = tc; e.acc = acc; e.b = b; e.pc = pc; e.seq = seq; e.nseq = nseq;
    e.wr = wr; e.wa = wa; e.wd = wd;
    q.push_back(e);
    tags.push_back(tag);
  endtask

  // bus model: two wait states for cycles addressed in 0010H..00FFH
  int wleft = 0;
  always @(negedge clk) begin
    if (mc_t1) begin
      wleft = (mc_addr >= 16'h0010 && mc_addr < 16'h0100) ? 2 : 0;
      bus_ready = 1'b1;
    end else if (rd_en || wr_en) begin
      bus_ready = (wleft == 0);
      if (wleft > 0) wleft--;
    end
  end

  // monitor
  logic [31:0] seq = 0, nseq = 0, wseen = 0, wa = 0, wd = 0;
  bit overlap = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en && wr_en) overlap = 1;
      if (instr_done) begin
        dones++;
        if (q.size() == 0) chk(0, "R10 unexpected done", 32'(dones), 0);
        else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = tags.pop_front();
          chk(tcount == e.tc[7:0], {t, " tcount"}, 32'(tcount), e.tc);
          chk(acc_out == e.acc[7:0], {t, " acc"}, 32'(acc_out), e.acc);
          chk(b_out == e.b[7:0], {t, " B"}, 32'(b_out), e.b);
          chk(pc_out == e.pc[15:0], {t, " R6 pc"}, 32'(pc_out), e.pc);
          chk(seq == e.seq && nseq == e.nseq, {t, " status seq"}, seq, e.seq);
          chk(wseen == e.wr && (e.wr == 0 || (wa == e.wa && wd == e.wd)), {t, " write"}, {wa[15:0], wd[7:0], wseen[7:0]}, {e.wa[15:0], e.wd[7:0], e.wr[7:0]});
          chk(overlap == 0, {t, " R9 strobes"}, 32'(overlap), 0);
        end
        seq = 0; nseq = 0; wseen = 0;
      end
      if (mc_t1) begin seq = {seq[28:0], mc_status}; nseq++; end
      if (wr_en) begin wseen = 1; wa = 32'(mc_addr); wd = 32'(mc_wdata); end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h00] = 8'h41;
    mem[8'h01] = 8'h06; mem[8'h02] = 8'h77;
    mem[8'h03] = 8'hC6; mem[8'h04] = 8'h03;
    mem[8'h05] = 8'hC6; mem[8'h06] = 8'h05;
    mem[8'h07] = 8'h32; mem[8'h08] = 8'h34; mem[8'h09] = 8'h12;
    mem[8'h0B] = 8'hC6; mem[8'h0C] = 8'hFF;
    mem[8'h10] = 8'h06; mem[8'h11] = 8'h99;
    mem[8'h12] = 8'h32; mem[8'h13] = 8'h20; mem[8'h14] = 8'h00;
    mem[8'h15] = 8'h41;
    mem[8'h16] = 8'hFF;

    push("R2 MOV B,C",        4,  'h00, 'h5A, 'h01, 'h3,   1, 0, 0, 0);
    push("R3 MVI B",          7,  'h00, 'h77, 'h03, 'h1A,  2, 0, 0, 0);
    push("R4 ADI 03",         7,  'h03, 'h77, 'h05, 'h1A,  2, 0, 0, 0);
    push("R4 ADI 05",         7,  'h08, 'h77, 'h07, 'h1A,  2, 0, 0, 0);
    push("R5 STA 1234",       13, 'h08, 'h77, 'h0A, 'h691, 4, 1, 'h1234, 'h08);
    push("R7 opcode 00",      4,  'h08, 'h77, 'h0B, 'h3,   1, 0, 0, 0);
    push("R4 ADI FF wrap",    7,  'h07, 'h77, 'h0D, 'h1A,  2, 0, 0, 0);
    push("R7 opcode 00 b",    4,  'h07, 'h77, 'h0E, 'h3,   1, 0, 0, 0);
    push("R7 opcode 00 c",    4,  'h07, 'h77, 'h0F, 'h3,   1, 0, 0, 0);
    push("R7 opcode 00 d",    4,  'h07, 'h77, 'h10, 'h3,   1, 0, 0, 0);
    push("R8 MVI waits",      11, 'h07, 'h99, 'h12, 'h1A,  2, 0, 0, 0);
    push("R8 STA waits",      21, 'h07, 'h99, 'h15, 'h691, 4, 1, 'h0020, 'h07);
    push("R8 MOV waits",      6,  'h07, 'h5A, 'h16, 'h3,   1, 0, 0, 0);
    push("R7 opcode FF",      6,  'h07, 'h5A, 'h17, 'h3,   1, 0, 0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mc_t1 == 1'b1, "R1 t1", 32'(mc_t1), 1);
    chk(mc_status == 3'b011, "R1 status", 32'(mc_status), 3);
    chk(mc_addr == 16'h0000, "R1 addr", 32'(mc_addr), 0);
    chk(pc_out == 16'h0000 && acc_out == 8'h00 && b_out == 8'h00, "R1 regs",
        {pc_out, acc_out, b_out}, 0);
    chk(instr_done == 1'b0, "R1 done", 32'(instr_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mc_t1 == 1'b0 && rd_en == 1'b1, "R9 fetch T2 read", {rd_en, mc_t1}, 2);

    for (int cyc = 0; cyc < 2000 && dones < 14; cyc++) @(negedge clk);
    chk(dones == 14, "R10 watchdog/instruction count", 32'(dones), 14);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule